// File: doc/BRIEF.md
# Accumulator-File Execute Unit with Skip

This block executes six operations of an 8-bit accumulator machine. State is an accumulator, a zero flag, a 128-entry file of 8-bit registers and a 15-bit program counter. Each operation arrives already decoded on an issue port as an operation code, a 7-bit file address, a destination bit and an 11-bit literal. A separate page-latch input provides the upper program-counter bits for the absolute jump. One operation is accepted on each clock edge where both valid and ready are high.

Increment-and-skip and decrement-and-skip never branch. When their result is zero, the next operation accepted is cancelled: it advances the PC and changes nothing else. The jump takes two cycles. The cycle after it is accepted is a hold cycle with ready low. The busy output marks the second cycle of any two-cycle operation, which is either the cancelled slot or the jump hold cycle.

The file registers are not cleared by reset. A user sets them up through the operations themselves.

Top module: `afx_exec_unit`

## Requirements
- R1: A synchronous reset sets PC to 0, the accumulator to 0 and the zero flag to 0, and drops any pending skip or jump hold. After reset, busy is 0 and ready is 1.
- R2: For file operations (codes 0, 1, 2, 4), destination bit 0 writes the result to the accumulator and leaves the file register unchanged. Destination bit 1 writes the result to the addressed file register and leaves the accumulator unchanged.
- R3: Code 0 (decrement-skip) computes file value minus 1. A zero result cancels the next accepted operation and raises busy until that slot is consumed. A nonzero result cancels nothing.
- R4: Code 2 (increment-skip) computes file value plus 1 modulo 256. A result that wraps to zero cancels the next accepted operation, in the same way as R3.
- R5: Codes 0 and 2 never change the zero flag.
- R6: Code 1 (increment), code 3 (OR with literal) and code 4 (OR accumulator with file) set the zero flag to 1 when their 8-bit result is 0 and to 0 otherwise.
- R7: Code 3 writes the accumulator OR literal bits [7:0] into the accumulator whatever the destination bit, and writes no file register.
- R8: Code 5 (jump) loads PC with page-latch bits [6:3] as PC[14:11] and literal bits [10:0] as PC[10:0]. In the next cycle ready is 0, busy is 1 and PC holds.
- R9: Every accepted operation that is not a jump advances PC by 1 modulo 2^15. This includes a cancelled slot. A cancelled slot changes neither the accumulator, the zero flag nor any file register.
- R10: Codes 6 and 7 are no-operations that only advance PC.
- R11: A pending skip stays pending, with busy high and PC held, for as long as no operation is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| iss_valid | input | 1 | An operation is offered |
| iss_ready | output | 1 | Unit can accept an operation this cycle |
| iss_op | input | 3 | Operation code, 0 to 7 |
| iss_fa | input | 7 | File register address |
| iss_dst | input | 1 | Destination select, 0 accumulator, 1 file |
| iss_lit | input | 11 | Literal: jump target low bits, or OR operand in bits [7:0] |
| page_latch | input | 7 | Page register; bits [6:3] form the jump's upper PC bits |
| pc_o | output | 15 | Program counter |
| acc_o | output | 8 | Accumulator |
| zero_o | output | 1 | Zero flag |
| busy_o | output | 1 | Second cycle of a two-cycle operation |

## Verification
Every result is registered. The accumulator, zero flag, PC and busy reflect an accepted operation right after the clock edge that accepts it. Ready falls one edge after a jump is accepted and rises on the edge after that. A cancelled slot shows its effect one edge after it is consumed.

The bench drives on the falling edge and checks at the next falling edge, which is one register stage later. File contents are read back through a later increment into the accumulator. Before driving, the bench waits at the falling edge for ready, so the jump hold cycle never shifts its checks.

// File: rtl/afx_pkg.sv
package afx_pkg;
  localparam int AFX_DW  = 8;
  localparam int AFX_AW  = 7;
  localparam int AFX_PCW = 15;
  localparam int AFX_JLW = 11;
  localparam int AFX_PLW = 7;
  localparam int AFX_PGW = AFX_PCW - AFX_JLW;

  typedef enum logic [2:0] {
    AFX_DECSKZ = 3'd0,
    AFX_INC    = 3'd1,
    AFX_INCSKZ = 3'd2,
    AFX_ORLIT  = 3'd3,
    AFX_ORFILE = 3'd4,
    AFX_JUMP   = 3'd5,
    AFX_RSV6   = 3'd6,
    AFX_RSV7   = 3'd7
  } afx_op_e;

  function automatic logic [AFX_DW-1:0] afx_dec(input logic [AFX_DW-1:0] v);
    return v - AFX_DW'(1);
  endfunction

  function automatic logic [AFX_DW-1:0] afx_inc(input logic [AFX_DW-1:0] v);
    return v + AFX_DW'(1);
  endfunction

  function automatic logic [AFX_DW-1:0] afx_or(input logic [AFX_DW-1:0] a,
                                               input logic [AFX_DW-1:0] b);
    return a | b;
  endfunction

  function automatic logic afx_is_zero(input logic [AFX_DW-1:0] v);
    return (v == '0);
  endfunction

  function automatic logic [AFX_PCW-1:0] afx_pc_step(input logic [AFX_PCW-1:0] pc);
    return pc + AFX_PCW'(1);
  endfunction

  function automatic logic [AFX_PCW-1:0] afx_jump_target(input logic [AFX_JLW-1:0] k,
                                                         input logic [AFX_PLW-1:0] pl);
    return {pl[AFX_PLW-1 -: AFX_PGW], k};
  endfunction
endpackage

// File: rtl/afx_regfile.sv
module afx_regfile #(
  parameter int DW = afx_pkg::AFX_DW,
  parameter int AW = afx_pkg::AFX_AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  assign rdata = mem[addr];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end
endmodule

// File: rtl/afx_alu.sv
module afx_alu
  import afx_pkg::*;
#(
  parameter int DW = AFX_DW
) (
  input  afx_op_e       op,
  input  logic [DW-1:0] fval,
  input  logic [DW-1:0] wval,
  input  logic [DW-1:0] lit,
  input  logic          dst,
  output logic [DW-1:0] res,
  output logic          wr_w,
  output logic          wr_f,
  output logic          upd_z,
  output logic          skip_hit,
  output logic          is_jump
);
  always_comb begin
    res      = '0;
    wr_w     = 1'b0;
    wr_f     = 1'b0;
    upd_z    = 1'b0;
    skip_hit = 1'b0;
    is_jump  = 1'b0;
    unique case (op)
      AFX_DECSKZ: begin
        res      = afx_dec(fval);
        wr_w     = !dst;
        wr_f     = dst;
        skip_hit = afx_is_zero(res);
      end
      AFX_INC: begin
        res   = afx_inc(fval);
        wr_w  = !dst;
        wr_f  = dst;
        upd_z = 1'b1;
      end
      AFX_INCSKZ: begin
        res      = afx_inc(fval);
        wr_w     = !dst;
        wr_f     = dst;
        skip_hit = afx_is_zero(res);
      end
      AFX_ORLIT: begin
        res   = afx_or(wval, lit);
        wr_w  = 1'b1;
        upd_z = 1'b1;
      end
      AFX_ORFILE: begin
        res   = afx_or(wval, fval);
        wr_w  = !dst;
        wr_f  = dst;
        upd_z = 1'b1;
      end
      AFX_JUMP: is_jump = 1'b1;
      default: ;
    endcase
  end

  // R7: OR with literal never targets a file register
  always_comb begin
    if (op == AFX_ORLIT) a_orlit_no_file_r7: assert (!wr_f);
  end
endmodule

// File: rtl/afx_seq.sv
module afx_seq
  import afx_pkg::*;
#(
  parameter int PCW = AFX_PCW,
  parameter int JLW = AFX_JLW,
  parameter int PLW = AFX_PLW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           iss_valid,
  input  logic           is_jump,
  input  logic           skip_hit,
  input  logic [JLW-1:0] jlit,
  input  logic [PLW-1:0] page,
  output logic           iss_ready,
  output logic           busy,
  output logic           exec,
  output logic           squash,
  output logic [PCW-1:0] pc
);
  logic accept;
  logic skip_pend;
  logic jmp_hold;

  assign iss_ready = !jmp_hold;
  assign busy      = skip_pend | jmp_hold;
  assign accept    = iss_valid & iss_ready;
  assign exec      = accept & !skip_pend;
  assign squash    = accept & skip_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc        <= '0;
      skip_pend <= 1'b0;
      jmp_hold  <= 1'b0;
    end else begin
      if (accept) skip_pend <= exec & skip_hit;
      jmp_hold <= exec & is_jump;
      if (exec && is_jump) pc <= afx_jump_target(jlit, page);
      else if (accept)     pc <= afx_pc_step(pc);
    end
  end

  // R1: state leaves reset cleared
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pc == '0 && !busy && iss_ready));
  // R8: jump target and hold cycle
  p_jump_target_r8: assert property (@(posedge clk) disable iff (rst)
    (exec && is_jump) |=> (pc == {$past(page[PLW-1 -: PCW-JLW]), $past(jlit)}));
  p_jump_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (exec && is_jump) |=> (!iss_ready && busy));
  p_hold_pc_r8: assert property (@(posedge clk) disable iff (rst)
    jmp_hold |=> $stable(pc));
  // R9: non-jump acceptance steps the PC
  p_pc_step_r9: assert property (@(posedge clk) disable iff (rst)
    (accept && !(exec && is_jump)) |=> (pc == $past(pc) + PCW'(1)));
  // R3 R4: zero result leaves a pending skip
  p_skip_arm_r3: assert property (@(posedge clk) disable iff (rst)
    (exec && skip_hit) |=> busy);
  // R11: pending skip waits for the next offered operation
  p_skip_wait_r11: assert property (@(posedge clk) disable iff (rst)
    (skip_pend && !iss_valid) |=> (busy && $stable(pc)));
endmodule

// File: rtl/afx_exec_unit.sv
module afx_exec_unit
  import afx_pkg::*;
#(
  parameter int DW  = AFX_DW,
  parameter int AW  = AFX_AW,
  parameter int PCW = AFX_PCW,
  parameter int JLW = AFX_JLW,
  parameter int PLW = AFX_PLW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           iss_valid,
  output logic           iss_ready,
  input  logic [2:0]     iss_op,
  input  logic [AW-1:0]  iss_fa,
  input  logic           iss_dst,
  input  logic [JLW-1:0] iss_lit,
  input  logic [PLW-1:0] page_latch,
  output logic [PCW-1:0] pc_o,
  output logic [DW-1:0]  acc_o,
  output logic           zero_o,
  output logic           busy_o
);
  afx_op_e       op_e;
  logic [DW-1:0] fval;
  logic [DW-1:0] res;
  logic          wr_w, wr_f, upd_z, skip_hit, is_jump;
  logic          exec, squash;
  logic          w_we, f_we, z_we;
  logic [DW-1:0] acc_q;
  logic          z_q;

  assign op_e = afx_op_e'(iss_op);

  afx_regfile #(.DW(DW), .AW(AW)) u_rf (
    .clk   (clk),
    .we    (f_we),
    .addr  (iss_fa),
    .wdata (res),
    .rdata (fval)
  );

  afx_alu #(.DW(DW)) u_alu (
    .op       (op_e),
    .fval     (fval),
    .wval     (acc_q),
    .lit      (iss_lit[DW-1:0]),
    .dst      (iss_dst),
    .res      (res),
    .wr_w     (wr_w),
    .wr_f     (wr_f),
    .upd_z    (upd_z),
    .skip_hit (skip_hit),
    .is_jump  (is_jump)
  );

  afx_seq #(.PCW(PCW), .JLW(JLW), .PLW(PLW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .iss_valid (iss_valid),
    .is_jump   (is_jump),
    .skip_hit  (skip_hit),
    .jlit      (iss_lit),
    .page      (page_latch),
    .iss_ready (iss_ready),
    .busy      (busy_o),
    .exec      (exec),
    .squash    (squash),
    .pc        (pc_o)
  );

  assign w_we = exec & wr_w;
  assign f_we = exec & wr_f;
  assign z_we = exec & upd_z;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      z_q   <= 1'b0;
    end else begin
      if (w_we) acc_q <= res;
      if (z_we) z_q   <= afx_is_zero(res);
    end
  end

  assign acc_o  = acc_q;
  assign zero_o = z_q;

  // R1: accumulator and flag clear after reset
  p_reset_acc_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (acc_o == '0 && !zero_o));
  // R2: file destination leaves the accumulator alone
  p_file_dst_keeps_w_r2: assert property (@(posedge clk) disable iff (rst)
    (exec && iss_dst && op_e != AFX_ORLIT) |=> $stable(acc_o));
  // R5: skip operations leave the flag alone
  p_skip_keeps_z_r5: assert property (@(posedge clk) disable iff (rst)
    (exec && (op_e == AFX_DECSKZ || op_e == AFX_INCSKZ)) |=> $stable(zero_o));
  // R6: OR with literal leaves the flag matching the accumulator
  p_orlit_z_r6: assert property (@(posedge clk) disable iff (rst)
    (exec && op_e == AFX_ORLIT) |=> (zero_o == (acc_o == '0)));
  // R7: accumulator takes the OR with the literal
  p_orlit_val_r7: assert property (@(posedge clk) disable iff (rst)
    (exec && op_e == AFX_ORLIT) |=> (acc_o == ($past(acc_o) | $past(iss_lit[DW-1:0]))));
  // R9: cancelled slot writes nothing
  p_squash_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    squash |=> ($stable(acc_o) && $stable(zero_o)));
  always_comb begin
    if (squash) a_squash_no_write_r9: assert (!f_we && !w_we && !z_we);
  end
  // R10: reserved codes touch no data state
  p_rsv_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (exec && (op_e == AFX_RSV6 || op_e == AFX_RSV7)) |=> ($stable(acc_o) && $stable(zero_o)));
endmodule

// File: tb/afx_exec_unit_tb_top.sv
module afx_exec_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [2:0]  op;
    logic [6:0]  fa;
    logic        d;
    logic [10:0] k;
    logic [6:0]  pl;
    logic [7:0]  w;
    logic        z;
    logic [14:0] pc;
    logic        busy;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  // starting point: reset state, file 0x00, 0x10, 0x11, 0x7F all zero
  localparam vec_t VECS [NV] = '{
    '{3'd3, 7'h00, 1'b0, 11'h000, 7'h00, 8'h00, 1'b1, 15'h0001, 1'b0, 4'd6},  // R6 or-lit zero
    '{3'd3, 7'h10, 1'b1, 11'h05A, 7'h00, 8'h5A, 1'b0, 15'h0002, 1'b0, 4'd7},  // R7 d ignored
    '{3'd4, 7'h10, 1'b1, 11'h000, 7'h00, 8'h5A, 1'b0, 15'h0003, 1'b0, 4'd2},  // R2 f10=5A
    '{3'd1, 7'h10, 1'b0, 11'h000, 7'h00, 8'h5B, 1'b0, 15'h0004, 1'b0, 4'd2},  // R2 read back
    '{3'd1, 7'h11, 1'b1, 11'h000, 7'h00, 8'h5B, 1'b0, 15'h0005, 1'b0, 4'd2},  // R2 f11=1
    '{3'd0, 7'h11, 1'b1, 11'h000, 7'h00, 8'h5B, 1'b0, 15'h0006, 1'b1, 4'd3},  // R3 skip f11=0
    '{3'd3, 7'h00, 1'b0, 11'h0FF, 7'h00, 8'h5B, 1'b0, 15'h0007, 1'b0, 4'd9},  // R9 cancelled
    '{3'd0, 7'h11, 1'b0, 11'h000, 7'h00, 8'hFF, 1'b0, 15'h0008, 1'b0, 4'd3},  // R3 no skip
    '{3'd1, 7'h7F, 1'b1, 11'h000, 7'h00, 8'hFF, 1'b0, 15'h0009, 1'b0, 4'd2},  // R2 f7F=1
    '{3'd4, 7'h7F, 1'b0, 11'h000, 7'h00, 8'hFF, 1'b0, 15'h000A, 1'b0, 4'd6},  // R6
    '{3'd2, 7'h00, 1'b1, 11'h000, 7'h00, 8'hFF, 1'b0, 15'h000B, 1'b0, 4'd4},  // R4 f0=1
    '{3'd0, 7'h11, 1'b1, 11'h000, 7'h00, 8'hFF, 1'b0, 15'h000C, 1'b0, 4'd3},  // R3 f11=FF
    '{3'd1, 7'h11, 1'b0, 11'h000, 7'h00, 8'h00, 1'b1, 15'h000D, 1'b0, 4'd6},  // R6 wrap zero
    '{3'd2, 7'h11, 1'b1, 11'h000, 7'h00, 8'h00, 1'b1, 15'h000E, 1'b1, 4'd4},  // R4 skip f11=0
    '{3'd1, 7'h00, 1'b0, 11'h000, 7'h00, 8'h00, 1'b1, 15'h000F, 1'b0, 4'd9},  // R9 cancelled
    '{3'd2, 7'h11, 1'b0, 11'h000, 7'h00, 8'h01, 1'b1, 15'h0010, 1'b0, 4'd5},  // R5 Z kept
    '{3'd5, 7'h00, 1'b0, 11'h7A5, 7'h5F, 8'h01, 1'b1, 15'h5FA5, 1'b1, 4'd8},  // R8 jump
    '{3'd3, 7'h00, 1'b0, 11'h080, 7'h00, 8'h81, 1'b0, 15'h5FA6, 1'b0, 4'd7},  // R7
    '{3'd6, 7'h10, 1'b1, 11'h3FF, 7'h00, 8'h81, 1'b0, 15'h5FA7, 1'b0, 4'd10}, // R10
    '{3'd7, 7'h11, 1'b1, 11'h3FF, 7'h00, 8'h81, 1'b0, 15'h5FA8, 1'b0, 4'd10}, // R10
    '{3'd5, 7'h00, 1'b0, 11'h7FF, 7'h7F, 8'h81, 1'b0, 15'h7FFF, 1'b1, 4'd8},  // R8 top page
    '{3'd1, 7'h10, 1'b0, 11'h000, 7'h00, 8'h5B, 1'b0, 15'h0000, 1'b0, 4'd9}   // R9 PC wrap
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        iss_valid = 1'b0;
  logic        iss_ready;
  logic [2:0]  iss_op = '0;
  logic [6:0]  iss_fa = '0;
  logic        iss_dst = 1'b0;
  logic [10:0] iss_lit = '0;
  logic [6:0]  page_latch = '0;
  logic [14:0] pc_o;
  logic [7:0]  acc_o;
  logic        zero_o;
  logic        busy_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  afx_exec_unit dut_i (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_op(iss_op), .iss_fa(iss_fa), .iss_dst(iss_dst), .iss_lit(iss_lit),
    .page_latch(page_latch), .pc_o(pc_o), .acc_o(acc_o), .zero_o(zero_o),
    .busy_o(busy_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic issue(input logic [2:0] op, input logic [6:0] fa, input logic d,
                       input logic [10:0] k, input logic [6:0] pl);
    while (!iss_ready) @(negedge clk);
    iss_op = op; iss_fa = fa; iss_dst = d; iss_lit = k; page_latch = pl;
    iss_valid = 1'b1;
    @(negedge clk);
    iss_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic zero_file(input logic [6:0] fa);
    for (int i = 0; i < 300; i++) begin
      issue(3'd0, fa, 1'b1, 11'h000, 7'h00);
      if (busy_o) begin
        issue(3'd3, 7'h00, 1'b0, 11'h000, 7'h00);
        break;
      end
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", "pc", 32'(pc_o), 32'h0);
    chk("R1", "acc", 32'(acc_o), 32'h0);
    chk("R1", "zero", 32'(zero_o), 32'h0);
    chk("R1", "busy", 32'(busy_o), 32'h0);
    chk("R1", "ready", 32'(iss_ready), 32'h1);

    zero_file(7'h00);
    zero_file(7'h10);
    zero_file(7'h11);
    zero_file(7'h7F);
    do_reset();

    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d", VECS[i].req);
      issue(VECS[i].op, VECS[i].fa, VECS[i].d, VECS[i].k, VECS[i].pl);
      chk(rq, $sformatf("v%0d acc", i), 32'(acc_o), 32'(VECS[i].w));
      chk(rq, $sformatf("v%0d zero", i), 32'(zero_o), 32'(VECS[i].z));
      chk(rq, $sformatf("v%0d pc", i), 32'(pc_o), 32'(VECS[i].pc));
      chk(rq, $sformatf("v%0d busy", i), 32'(busy_o), 32'(VECS[i].busy));
      if (VECS[i].op == 3'd5) chk("R8", "ready in hold", 32'(iss_ready), 32'h0);
    end

    // R11: pending skip survives idle cycles; f0 is 1 here
    issue(3'd0, 7'h00, 1'b1, 11'h000, 7'h00);
    chk("R3", "skip busy", 32'(busy_o), 32'h1);
    repeat (3) @(negedge clk);
    chk("R11", "busy idle", 32'(busy_o), 32'h1);
    chk("R11", "pc idle", 32'(pc_o), 32'h1);
    chk("R11", "ready idle", 32'(iss_ready), 32'h1);
    issue(3'd1, 7'h10, 1'b1, 11'h000, 7'h00);
    chk("R9", "cancelled pc", 32'(pc_o), 32'h2);
    chk("R9", "cancelled busy", 32'(busy_o), 32'h0);
    issue(3'd1, 7'h10, 1'b0, 11'h000, 7'h00);
    chk("R9", "file kept by cancelled slot", 32'(acc_o), 32'h5B);

    // R1: reset clears a pending skip; f7F is 1 here
    issue(3'd0, 7'h7F, 1'b1, 11'h000, 7'h00);
    chk("R3", "skip armed", 32'(busy_o), 32'h1);
    do_reset();
    chk("R1", "pc after reset", 32'(pc_o), 32'h0);
    chk("R1", "acc after reset", 32'(acc_o), 32'h0);
    chk("R1", "busy after reset", 32'(busy_o), 32'h0);
    issue(3'd3, 7'h00, 1'b0, 11'h033, 7'h00);
    chk("R1", "no skip after reset", 32'(acc_o), 32'h33);
    chk("R1", "pc step after reset", 32'(pc_o), 32'h1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule